// File: doc/BRIEF.md
# Branch Hint Fetch Controller

This block steers instruction fetch for a core that has no dynamic branch predictor and relies on software hints. A hint write places one branch address and its destination in a single hint slot. When fetch later reaches that branch address and the branch resolves taken to the hinted destination, fetch moves to the destination on the next cycle with no stall. This only happens if the hint has aged enough: the write must come a fixed minimum number of cycles (11 by default) before the branch. A newer hint overwrites the slot. Hints are never queued.

Any taken branch that the slot does not cover stalls fetch for a fixed penalty (18 cycles by default) and then resumes at the branch destination. Other cases that stall for the penalty are a hint that is too young, a hint for a different address, and a hinted branch whose real destination differs from the hint. When a branch was hinted and armed but resolves not-taken, fetch has already been steered away, so it pays the same penalty and then resumes at the fall-through address. An unhinted not-taken branch costs nothing. The environment reports each fetched branch, with its outcome and destination, in the cycle in which it is fetched. The block drives the fetch address and a stall flag.

Top module: `bhc_fetch_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycles after its release, fetch_pc equals RESET_PC (default 0) and fetch_stall is low.
- R2: In a cycle with no stall and br_valid low, fetch_pc advances by INSTR_BYTES (default 4) at the next clock edge.
- R3: Suppose a hint is written at edge H and a taken branch is reported at edge H+d, at the hinted address and to the hinted destination. If d is at least HINT_LEAD (default 11), fetch_pc becomes the destination at that edge and no stall cycle follows.
- R4: The same hinted taken branch with d below HINT_LEAD stalls fetch for exactly MISS_PENALTY (default 18) cycles, then fetch_pc becomes the destination.
- R5: A taken branch with no matching hint raises fetch_stall for exactly MISS_PENALTY cycles. During those cycles fetch_pc holds the branch address. Then fetch_pc becomes br_dest_addr.
- R6: A not-taken branch with no armed matching hint causes no stall, and fetch_pc advances to the branch address plus INSTR_BYTES.
- R7: A not-taken branch at an armed hinted address stalls for MISS_PENALTY cycles, then fetch resumes at the branch address plus INSTR_BYTES.
- R8: The slot holds one hint. A second hint write replaces the first, and a branch at the first hint's address is then treated as unhinted.
- R9: A branch at the hinted address consumes the hint. A second visit to that branch with no new hint write pays the full penalty.
- R10: Branch reports that arrive while fetch_stall is high are ignored. They change neither the stall length nor the resume address.
- R11: If a hint write and a branch that consumes the old hint fall on the same edge, the branch is judged against the old hint. The new hint is installed and its age counts from that edge.
- R12: An armed matching taken branch whose br_dest_addr differs from the hinted destination stalls for MISS_PENALTY cycles and then resumes at br_dest_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hint_wr | input | 1 | Write the hint slot this cycle |
| hint_branch_addr | input | PC_W | Address of the branch the hint covers |
| hint_dest_addr | input | PC_W | Predicted destination of that branch |
| br_valid | input | 1 | The instruction at fetch_pc is a branch, resolved this cycle |
| br_taken | input | 1 | Branch outcome |
| br_dest_addr | input | PC_W | Branch destination when taken |
| fetch_pc | output | PC_W | Current fetch address |
| fetch_stall | output | 1 | Fetch is paying a redirect penalty |

## Verification
A hint write and a branch can land on the same clock edge, and the two act on the slot in opposite directions: the branch consumes and clears it while the write fills it. The bench reaches a matching branch with an armed hint and, on that same edge, writes a hint for a later address. It then expects a penalty-free redirect for the current branch and a second penalty-free redirect exactly 11 fetches after the first destination. That result shows the write won the slot and that its age started at the shared edge. A second overlap puts branch reports inside a running penalty window. The bench checks that the stall length and the resume address do not change.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  // Outcome of one branch report against the hint slot
  typedef enum logic [1:0] {
    VERDICT_SEQ  = 2'd0,
    VERDICT_HIT  = 2'd1,
    VERDICT_MISS = 2'd2
  } br_verdict_e;

endpackage

// File: rtl/bhc_reset_sync.sv
module bhc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bhc_hint_slot.sv
module bhc_hint_slot #(
  parameter int PC_W = 32,
  parameter int LEAD = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [PC_W-1:0] wr_branch,
  input  logic [PC_W-1:0] wr_dest,
  input  logic            consume,
  output logic            valid,
  output logic            armed,
  output logic [PC_W-1:0] branch,
  output logic [PC_W-1:0] dest
);

  localparam int AGE_W = $clog2(LEAD + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(LEAD);
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

  logic            valid_q, valid_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic [PC_W-1:0] branch_q, branch_d;
  logic [PC_W-1:0] dest_q, dest_d;
  logic            addr_en;

  // next-state: a write wins over a same-cycle consume
  always_comb begin
    valid_d  = valid_q;
    age_d    = age_q;
    addr_en  = 1'b0;
    branch_d = wr_branch;
    dest_d   = wr_dest;
    if (wr) begin
      valid_d = 1'b1;
      age_d   = AGE_ONE;
      addr_en = 1'b1;
    end else if (consume) begin
      valid_d = 1'b0;
      age_d   = '0;
    end else if (valid_q && (age_q < AGE_MAX)) begin
      age_d = age_q + AGE_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      age_q   <= '0;
    end else begin
      valid_q <= valid_d;
      age_q   <= age_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      branch_q <= '0;
      dest_q   <= '0;
    end else if (addr_en) begin
      branch_q <= branch_d;
      dest_q   <= dest_d;
    end
  end

  assign valid  = valid_q;
  assign armed  = valid_q && (age_q >= AGE_MAX);
  assign branch = branch_q;
  assign dest   = dest_q;

  // R3: age saturates at the lead distance
  p_age_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    age_q <= AGE_MAX);

  // R9: a consumed hint is gone at the next cycle
  p_consume_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !wr) |=> !valid_q);

  // R11: a write always yields a fresh, valid hint of age one
  p_write_fresh_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (valid_q && age_q == AGE_ONE));

endmodule

// File: rtl/bhc_penalty_timer.sv
module bhc_penalty_timer #(
  parameter int PC_W    = 32,
  parameter int PENALTY = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] load_dest,
  output logic            busy,
  output logic            expire,
  output logic [PC_W-1:0] resume_pc
);

  localparam int CNT_W = $clog2(PENALTY + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PENALTY);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PC_W-1:0]  dest_q;

  always_comb begin
    if (load) begin
      cnt_d = CNT_FULL;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_ONE;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
    end else if (load) begin
      dest_q <= load_dest;
    end
  end

  assign busy      = (cnt_q != '0);
  assign expire    = (cnt_q == CNT_ONE);
  assign resume_pc = dest_q;

  // R10: a penalty window is never restarted while running
  p_no_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));

  // R5: the window counts down one per cycle
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  // R5: the resume address is stable across the window
  p_dest_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(dest_q));

endmodule

// File: rtl/bhc_fetch_ctrl.sv
module bhc_fetch_ctrl #(
  parameter int PC_W         = 32,
  parameter int INSTR_BYTES  = 4,
  parameter int HINT_LEAD    = 11,
  parameter int MISS_PENALTY = 18,
  parameter int RESET_PC     = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hint_wr,
  input  logic [PC_W-1:0] hint_branch_addr,
  input  logic [PC_W-1:0] hint_dest_addr,
  input  logic            br_valid,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_dest_addr,
  output logic [PC_W-1:0] fetch_pc,
  output logic            fetch_stall
);

  import bhc_pkg::*;

  localparam logic [PC_W-1:0] STEP    = PC_W'(INSTR_BYTES);
  localparam logic [PC_W-1:0] PC_INIT = PC_W'(RESET_PC);

  logic            rst_sync_n;
  logic            slot_valid, slot_armed;
  logic [PC_W-1:0] slot_branch, slot_dest;
  logic            tmr_busy, tmr_expire;
  logic [PC_W-1:0] tmr_resume;

  logic            br_act, slot_match, consume;
  br_verdict_e     verdict;
  logic [PC_W-1:0] miss_dest;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;

  bhc_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bhc_hint_slot #(.PC_W(PC_W), .LEAD(HINT_LEAD)) u_slot (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (hint_wr),
    .wr_branch (hint_branch_addr),
    .wr_dest   (hint_dest_addr),
    .consume   (consume),
    .valid     (slot_valid),
    .armed     (slot_armed),
    .branch    (slot_branch),
    .dest      (slot_dest)
  );

  bhc_penalty_timer #(.PC_W(PC_W), .PENALTY(MISS_PENALTY)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (verdict == VERDICT_MISS),
    .load_dest (miss_dest),
    .busy      (tmr_busy),
    .expire    (tmr_expire),
    .resume_pc (tmr_resume)
  );

  // branch judgement against the slot contents before any same-cycle write
  always_comb begin
    br_act     = br_valid && !tmr_busy;
    slot_match = slot_valid && (slot_branch == pc_q);
    consume    = br_act && slot_match;
    verdict    = VERDICT_SEQ;
    miss_dest  = pc_q + STEP;
    if (br_act) begin
      if (br_taken) begin
        miss_dest = br_dest_addr;
        if (slot_match && slot_armed && (br_dest_addr == slot_dest)) begin
          verdict = VERDICT_HIT;
        end else begin
          verdict = VERDICT_MISS;
        end
      end else if (slot_match && slot_armed) begin
        verdict = VERDICT_MISS;
      end
    end
  end

  // next fetch address
  always_comb begin
    pc_en = 1'b1;
    pc_d  = pc_q + STEP;
    if (tmr_expire) begin
      pc_d = tmr_resume;
    end else if (tmr_busy || (verdict == VERDICT_MISS)) begin
      pc_en = 1'b0;
      pc_d  = pc_q;
    end else if (verdict == VERDICT_HIT) begin
      pc_d = slot_dest;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= PC_INIT;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign fetch_pc    = pc_q;
  assign fetch_stall = tmr_busy;

  // R2: idle fetch steps by one instruction
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fetch_stall && !br_valid) |=> (fetch_pc == $past(fetch_pc) + STEP));

  // R5: the address is frozen while a penalty runs
  p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_stall |-> $stable(fetch_pc));

  // R3: a covered branch redirects with no stall
  p_hit_free_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (verdict == VERDICT_HIT) |=> (!fetch_stall && fetch_pc == $past(slot_dest)));

  // R4: a miss opens a penalty window
  p_miss_stall_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (verdict == VERDICT_MISS) |=> fetch_stall);

  // R6: no hint, not taken, no cost
  p_nt_free_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_act && !br_taken && !slot_match) |=> !fetch_stall);

endmodule

// File: tb/bhc_fetch_ctrl_tb.sv
module bhc_fetch_ctrl_tb;

  localparam int PC_W    = 32;
  localparam int LEAD    = 11;
  localparam int PENALTY = 18;

  logic            clk;
  logic            rst_n;
  logic            hint_wr;
  logic [PC_W-1:0] hint_branch_addr;
  logic [PC_W-1:0] hint_dest_addr;
  logic            br_valid;
  logic            br_taken;
  logic [PC_W-1:0] br_dest_addr;
  logic [PC_W-1:0] fetch_pc;
  logic            fetch_stall;

  int n_chk;
  int n_fail;
  bit done;

  bhc_fetch_ctrl u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .hint_wr          (hint_wr),
    .hint_branch_addr (hint_branch_addr),
    .hint_dest_addr   (hint_dest_addr),
    .br_valid         (br_valid),
    .br_taken         (br_taken),
    .br_dest_addr     (br_dest_addr),
    .fetch_pc         (fetch_pc),
    .fetch_stall      (fetch_stall)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_hint(input logic [PC_W-1:0] b, input logic [PC_W-1:0] t);
    hint_wr = 1'b1;
    hint_branch_addr = b;
    hint_dest_addr = t;
    tick();
    hint_wr = 1'b0;
  endtask

  task automatic reach(input logic [PC_W-1:0] b);
    for (int g = 0; g < 2000; g++) begin
      if (fetch_pc == b && !fetch_stall) break;
      tick();
    end
  endtask

  task automatic fire(input logic [PC_W-1:0] b, input bit tk, input logic [PC_W-1:0] t);
    reach(b);
    br_valid = 1'b1;
    br_taken = tk;
    br_dest_addr = t;
    tick();
    br_valid = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (fetch_stall && n < 100) begin
      n++;
      tick();
    end
  endtask

  task automatic expect_after(input string req, input int exp_n, input logic [PC_W-1:0] exp_pc);
    int n;
    measure(n);
    check(n == exp_n, {req, " stall cycles"}, n, exp_n);
    check(fetch_pc == exp_pc, {req, " resume pc"}, fetch_pc, exp_pc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] p, b, t, c, u;
    int n;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; hint_wr = 1'b0; hint_branch_addr = '0; hint_dest_addr = '0;
    br_valid = 1'b0; br_taken = 1'b0; br_dest_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(fetch_pc == 0, "R1 pc in reset", fetch_pc, 0);
    check(!fetch_stall, "R1 stall in reset", fetch_stall, 0);
    rst_n = 1'b1;
    tick();
    check(fetch_pc == 0 && !fetch_stall, "R1 pc after release", fetch_pc, 0);
    repeat (3) tick();

    // R2: sequential stepping
    for (int k = 0; k < 4; k++) begin
      p = fetch_pc;
      tick();
      check(fetch_pc == p + 4, "R2 step", fetch_pc, p + 4);
    end

    // R3/R4: taken branch, lead sweep
    for (int d = 1; d <= 14; d++) begin
      p = fetch_pc;
      b = p + 32'(4 * d);
      t = p + 32'h1000;
      write_hint(b, t);
      fire(b, 1'b1, t);
      expect_after((d >= LEAD) ? "R3 lead sweep" : "R4 lead sweep",
                   (d >= LEAD) ? 0 : PENALTY, t);
    end

    // R7/R6: hinted not-taken, lead sweep
    for (int d = 1; d <= 14; d++) begin
      p = fetch_pc;
      b = p + 32'(4 * d);
      t = p + 32'h1000;
      write_hint(b, t);
      fire(b, 1'b0, t);
      expect_after((d >= LEAD) ? "R7 not-taken sweep" : "R6 young hint not-taken",
                   (d >= LEAD) ? PENALTY : 0, b + 4);
    end

    // R5: unhinted taken
    p = fetch_pc; b = p + 20; t = p + 32'h800;
    fire(b, 1'b1, t);
    check(fetch_stall && fetch_pc == b, "R5 hold at branch", fetch_pc, b);
    expect_after("R5 unhinted taken", PENALTY, t);

    // R6: unhinted not-taken
    p = fetch_pc; b = p + 12;
    fire(b, 1'b0, p + 32'h900);
    expect_after("R6 unhinted not-taken", 0, b + 4);

    // R8: second write replaces the first
    p = fetch_pc; b = p + 80; c = p + 120; t = p + 32'h2000;
    write_hint(b, t);
    write_hint(c, t + 32'h100);
    fire(b, 1'b1, t);
    expect_after("R8 replaced hint", PENALTY, t);

    // R9: consumed hint does not cover a second visit
    p = fetch_pc; b = p + 48; t = b - 8;
    write_hint(b, t);
    fire(b, 1'b1, t);
    expect_after("R9 first visit", 0, t);
    fire(b, 1'b1, t);
    expect_after("R9 second visit", PENALTY, t);

    // R10: branch reports during a stall are ignored
    p = fetch_pc; b = p + 16; t = p + 32'h3000;
    fire(b, 1'b1, t);
    n = 0;
    while (fetch_stall && n < 100) begin
      n++;
      if (n == 3 || n == 10) begin
        br_valid = 1'b1; br_taken = 1'b1; br_dest_addr = t + 32'h40;
      end
      tick();
      br_valid = 1'b0;
    end
    check(n == PENALTY, "R10 stall length", n, PENALTY);
    check(fetch_pc == t, "R10 resume pc", fetch_pc, t);

    // R11: hint write on the same edge as a consuming branch
    p = fetch_pc; b = p + 48; t = p + 32'h4000;
    c = t + 44; u = t + 32'h5000;
    write_hint(b, t);
    reach(b);
    br_valid = 1'b1; br_taken = 1'b1; br_dest_addr = t;
    hint_wr = 1'b1; hint_branch_addr = c; hint_dest_addr = u;
    tick();
    br_valid = 1'b0; hint_wr = 1'b0;
    expect_after("R11 old hint used", 0, t);
    fire(c, 1'b1, u);
    expect_after("R11 new hint armed", 0, u);

    // R12: armed hint with wrong destination
    p = fetch_pc; b = p + 60; t = p + 32'h6000;
    write_hint(b, t);
    fire(b, 1'b1, t + 8);
    expect_after("R12 wrong destination", PENALTY, t + 8);

    // R2 again after all redirects
    p = fetch_pc;
    tick();
    check(fetch_pc == p + 4, "R2 final step", fetch_pc, p + 4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule